// File: doc/BRIEF.md
# Fixed-Latency Completion Flag Generator

This block produces the completion pulse for a unit whose work always takes the same number of cycles, LATENCY, and which is started through a go/done handshake. A state counter stands in for the unit's datapath. It rests at state 0 while idle, leaves state 0 only when go is high, and then steps through every state up to LATENCY-1 before it wraps back to 0.

A one-bit start flag records whether a run was launched. The flag can change only while the counter sits at state 0. Done is raised when the counter is back at 0 and the flag is set. When go stays high across that cycle, the finishing run reports done in the same cycle that the next run begins.

When LATENCY is 1 there is no counter. The flag loads go on every cycle, and done is the flag, so it is go delayed by one cycle.

Top module: `sc_done_gen`

## Requirements
- R1: While the counter is in any state other than 0, the start flag keeps its value, so go pulses in the middle of a run change neither that run's done nor any later done.
- R2: In state 0 the flag loads go: 1 when go is high and 0 when it is low. This holds even in a cycle where done is asserted. A run that ends with go low therefore produces exactly one done.
- R3: Done is high exactly when the counter is in state 0 and the flag is 1. A run started in cycle t gives done in cycle t+LATENCY.
- R4: With go held high through state 0, runs follow back to back, and done repeats every LATENCY cycles, each time in the cycle where the next run starts.
- R5: The counter stays in state 0 while go is low there. After leaving 0 it counts through states 1 to LATENCY-1 whatever go does, so state_zero is low for exactly LATENCY-1 cycles per run.
- R6: During and right after reset the flag is 0, so done is low, and the counter is in state 0, so state_zero is high.
- R7: With LATENCY=1, done in each cycle equals go in the previous cycle, and state_zero is tied high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start request; a run begins when go is high in state 0 |
| done | output | 1 | Completion pulse for the run that just ended |
| state_zero | output | 1 | High while the state counter is in state 0 |

## Verification
The bench drives a LATENCY=4 instance and a LATENCY=1 instance from the same go stream. Its corner cases are these:
- **Go pulses during a run.** A flag that loaded on every cycle would produce phantom or missing done pulses.
- **Go held high across the return to state 0.** A design that gave priority to clearing the flag on done would drop every second run in a back-to-back train.
- **Go dropped exactly at the return to state 0.** A flag that failed to clear would repeat done forever.
- **Long idle gaps.** A counter that left state 0 without go would start false runs.

// File: rtl/sc_done_pkg.sv
package sc_done_pkg;

  // Width of a state counter that covers states 0 .. n-1 (at least 1 bit).
  function automatic int sc_cnt_width(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

  // Next counter state: leave 0 only on go, then run to n-1 and wrap.
  function automatic int sc_next_state(input int s, input logic go, input int n);
    if (s == 0)
      return go ? 1 : 0;
    else if (s >= n - 1)
      return 0;
    else
      return s + 1;
  endfunction

endpackage

// File: rtl/sc_state_counter.sv
module sc_state_counter
  import sc_done_pkg::*;
#(
  parameter int LATENCY = 4,
  localparam int CNT_W = sc_cnt_width(LATENCY)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic at_zero
);
  logic [CNT_W-1:0] state_q;
  logic [CNT_W-1:0] state_d;

  always_comb state_d = CNT_W'(sc_next_state(int'(state_q), go, LATENCY));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end

  assign at_zero = (state_q == '0);
endmodule

// File: rtl/sc_start_flag.sv
module sc_start_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_val,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag <= 1'b0;
    else if (wr_en) flag <= wr_val;
  end
endmodule

// File: rtl/sc_done_gen.sv
module sc_done_gen #(
  parameter int LATENCY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic done,
  output logic state_zero
);
  logic flag_wr_en;
  logic flag_q;

  generate
    if (LATENCY > 1) begin : g_counted
      logic cnt_zero;
      sc_state_counter #(.LATENCY(LATENCY)) u_cnt (
        .clk(clk), .rst_n(rst_n), .go(go), .at_zero(cnt_zero)
      );
      assign state_zero = cnt_zero;
      assign flag_wr_en = cnt_zero;
      assign done       = cnt_zero & flag_q;
    end else begin : g_single
      assign state_zero = 1'b1;
      assign flag_wr_en = 1'b1;
      assign done       = flag_q;
    end
  endgenerate

  sc_start_flag u_flag (
    .clk(clk), .rst_n(rst_n), .wr_en(flag_wr_en), .wr_val(go), .flag(flag_q)
  );
endmodule

// File: rtl/sc_done_gen_chk.sv
module sc_done_gen_chk #(
  parameter int LATENCY = 4
) (
  input logic clk,
  input logic rst_n,
  input logic go,
  input logic done,
  input logic state_zero,
  input logic flag
);
  generate
    if (LATENCY > 1) begin : g_cnt_chk
      p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !state_zero |=> flag == $past(flag));
      p_flag_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        state_zero |=> flag == $past(go));
      p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_zero);
      p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && go) |=> !state_zero && flag);
      p_idle_stays_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_zero && !go) |=> state_zero && !done);
    end else begin : g_one_chk
      p_delay_go_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> done == $past(go));
      p_idle_tied_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> state_zero);
    end
  endgenerate

  always @(negedge clk) begin
    if (!rst_n) p_reset_quiet_r6: assert (!done);
  end
endmodule

bind sc_done_gen sc_done_gen_chk #(.LATENCY(LATENCY)) u_chk (
  .clk(clk), .rst_n(rst_n), .go(go), .done(done),
  .state_zero(state_zero), .flag(flag_q)
);

// File: tb/sim_sc_done_gen.sv
module sim_sc_done_gen;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic done4, zero4, done1, zero1;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string cur_req = "R5";

  typedef struct {
    logic  d4;
    logic  z4;
    logic  d1;
    string req;
  } exp_t;
  exp_t q[$];

  // Reference model state
  int   m_phase = 0;
  logic m_armed = 1'b0;
  logic m_prev_go = 1'b0;

  always #5 clk = ~clk;

  sc_done_gen #(.LATENCY(N)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .done(done4), .state_zero(zero4)
  );
  sc_done_gen #(.LATENCY(1)) u1 (
    .clk(clk), .rst_n(rst_n), .go(go), .done(done1), .state_zero(zero1)
  );

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Driver: at the falling edge, record what this cycle must show, then set go.
  task automatic step(input logic g);
    exp_t e;
    @(negedge clk);
    e.d4  = (m_phase == 0) && m_armed;
    e.z4  = (m_phase == 0);
    e.d1  = m_prev_go;
    e.req = cur_req;
    q.push_back(e);
    go = g;
    if (m_phase == 0) begin
      m_armed = g;
      m_phase = g ? 1 : 0;
    end else begin
      m_phase = (m_phase + 1) % N;
    end
    m_prev_go = g;
  endtask

  // Monitor: pop and compare shortly after the falling edge.
  always @(negedge clk) begin
    cyc++;
    #1;
    if (rst_n && q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.req, done4, e.d4, "done N=4");
      chk(e.req, zero4, e.z4, "state_zero N=4");
      chk("R7", done1, e.d1, "done N=1");
      chk("R7", zero1, 1'b1, "state_zero N=1");
    end
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    repeat (3) @(posedge clk);
    #2;
    chk("R6", done4, 1'b0, "done in reset");
    chk("R6", zero4, 1'b1, "state_zero in reset");
    chk("R6", done1, 1'b0, "done N=1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R6", done4, 1'b0, "done after reset");
    chk("R6", zero4, 1'b1, "state_zero after reset");

    // R5: idle without go
    cur_req = "R5";
    for (int i = 0; i < 5; i++) step(1'b0);

    // R3: single run, then idle
    cur_req = "R3";
    step(1'b1);
    for (int i = 0; i < 8; i++) step(1'b0);

    // R1: go toggles during the run, low on return
    cur_req = "R1";
    step(1'b1);
    step(1'b0); step(1'b1); step(1'b1);
    for (int i = 0; i < 7; i++) step(1'b0);

    // R4: back-to-back runs with go held high
    cur_req = "R4";
    for (int i = 0; i < 13; i++) step(1'b1);
    for (int i = 0; i < 6; i++) step(1'b0);

    // R2: go held through a run, dropped exactly on return to 0
    cur_req = "R2";
    for (int i = 0; i < N; i++) step(1'b1);
    for (int i = 0; i < 9; i++) step(1'b0);

    // R7: alternating go pattern for the single-cycle variant
    cur_req = "R3";
    for (int i = 0; i < 12; i++) step(i[0]);
    for (int i = 0; i < 6; i++) step(1'b0);

    @(negedge clk);
    #3;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule